// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

A bank of up to 32 general-purpose pins behind a simple register bus. Each pin is a plain input, a plain output, or an interrupt source. An interrupt source senses a level (high or low) or an edge (rising, falling or, when the build allows it, both). A combined interrupt line goes high while any pin has a pending, enabled event. Software enables pins through a set-only unmask register and an AND-style mask register, and clears latched edge events by writing ones.

Pad inputs pass through a two-flop synchroniser before any sensing. Level status follows the synchronised input and is never latched. Edge status is sticky until cleared. When software reads the input-data register, a pin driven as an output reports its output-data bit, not the pad.

The bus is a valid/write/address/data interface. Writes take effect at the clock edge where `bus_valid && bus_write`. Reads are combinational and return zero while no read is presented.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pad_oe` is 0 and `irq` is 0.
- R2: A pin's `pad_oe` bit is 1 only when its mode bit (0x00) is 0 and its direction bit (0x04) is 1; `pad_out` always carries the output-data register (0x08).
- R3: Reading 0x0C gives, for each pin with `pad_oe` set, its output-data bit; for every other pin it gives the pad value, which appears two clock edges after the pad changes.
- R4: For a pin with mode=1 and sense bit (0x24) = 0, the status bit (0x10) is the synchronised pad XOR the polarity bit (0x20), with polarity 0 meaning active-high; it falls as soon as the condition goes away.
- R5: For a pin with mode=1 and sense bit = 1, a rising synchronised transition (polarity 0) or a falling one (polarity 1) sets a sticky status bit one edge after the synchronised transition (three edges after the pad).
- R6: With BOTH_EDGE_EN=1, a 1 in register 0x4C makes an edge pin trigger on both transitions whatever its polarity; with BOTH_EDGE_EN=0, 0x4C reads 0 and writing it changes no behaviour.
- R7: Writing 1s to 0x14 clears those sticky status bits; 0s have no effect; an edge event in the same cycle as its clear leaves the bit set.
- R8: Writing 0x1C ORs the written data into the enable register (0x18); writing 0x18 ANDs the enable register with the written data.
- R9: `irq` is 1 exactly when some pin has both status and enable set.
- R10: A pin whose mode bit is 0 shows status 0 and never raises `irq`.
- R11: Register 0x28, unmapped addresses, and bits at or above NPIN read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read |
| pad_in | input | NPIN | Asynchronous pad inputs |
| pad_out | output | NPIN | Output data to the pads |
| pad_oe | output | NPIN | Per-pin output driver enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench sweeps every pin through all five sense types: level-high, level-low, rising, falling and both. For each pin it checks status and `irq` after each pad transition, so a swapped polarity or a level path that latched would show up immediately. It writes a clear in the same cycle an edge arrives, which catches a design where the clear wins and the event is lost. It also checks that 0 bits in a clear write and 1 bits in a mask write leave state alone, which catches plain-write register semantics. A second, eight-pin instance built without both-edge support must read 0x4C as zero and must ignore the falling edge, which exposes a design that keeps the option regardless of the build parameter.

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank #(
  parameter int NPIN = 32,
  parameter bit BOTH_EDGE_EN = 1'b1,
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            irq
);
  localparam logic [AW-1:0] A_MODE  = AW'(8'h00);
  localparam logic [AW-1:0] A_DIR   = AW'(8'h04);
  localparam logic [AW-1:0] A_DOUT  = AW'(8'h08);
  localparam logic [AW-1:0] A_DIN   = AW'(8'h0C);
  localparam logic [AW-1:0] A_STAT  = AW'(8'h10);
  localparam logic [AW-1:0] A_CLR   = AW'(8'h14);
  localparam logic [AW-1:0] A_MASK  = AW'(8'h18);
  localparam logic [AW-1:0] A_UNMSK = AW'(8'h1C);
  localparam logic [AW-1:0] A_POL   = AW'(8'h20);
  localparam logic [AW-1:0] A_SENSE = AW'(8'h24);
  localparam logic [AW-1:0] A_BOTH  = AW'(8'h4C);

  logic [NPIN-1:0] irq_mode, dir, dout, ien, pol, sense, both;
  logic [NPIN-1:0] sync1, sync2, prev, sticky;
  logic [NPIN-1:0] rise, fall, evt, level, status, clr_mask, din_view;

  wire             wr = bus_valid & bus_write;
  wire             rd = bus_valid & ~bus_write;
  wire [NPIN-1:0]  wd = bus_wdata[NPIN-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_mode <= '0;
      dir      <= '0;
      dout     <= '0;
      ien      <= '0;
      pol      <= '0;
      sense    <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_MODE:  irq_mode <= wd;
        A_DIR:   dir      <= wd;
        A_DOUT:  dout     <= wd;
        A_MASK:  ien      <= ien & wd;
        A_UNMSK: ien      <= ien | wd;
        A_POL:   pol      <= wd;
        A_SENSE: sense    <= wd;
        default: ;
      endcase
    end
  end

  generate
    if (BOTH_EDGE_EN) begin : g_both
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) both <= '0;
        else if (wr && bus_addr == A_BOTH) both <= wd;
      end
    end else begin : g_noboth
      assign both = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign rise  = sync2 & ~prev;
  assign fall  = ~sync2 & prev;
  assign evt   = irq_mode & sense &
                 ((both & (rise | fall)) | (~both & ~pol & rise) | (~both & pol & fall));
  assign clr_mask = (wr && bus_addr == A_CLR) ? wd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= (sticky & ~clr_mask) | evt;
  end

  assign level    = sync2 ^ pol;
  assign status   = irq_mode & ((sense & sticky) | (~sense & level));
  assign irq      = |(status & ien);
  assign pad_oe   = dir & ~irq_mode;
  assign pad_out  = dout;
  assign din_view = (pad_oe & dout) | (~pad_oe & sync2);

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        A_MODE:  bus_rdata[NPIN-1:0] = irq_mode;
        A_DIR:   bus_rdata[NPIN-1:0] = dir;
        A_DOUT:  bus_rdata[NPIN-1:0] = dout;
        A_DIN:   bus_rdata[NPIN-1:0] = din_view;
        A_STAT:  bus_rdata[NPIN-1:0] = status;
        A_MASK:  bus_rdata[NPIN-1:0] = ien;
        A_POL:   bus_rdata[NPIN-1:0] = pol;
        A_SENSE: bus_rdata[NPIN-1:0] = sense;
        A_BOTH:  bus_rdata[NPIN-1:0] = both;
        default: bus_rdata = '0;
      endcase
    end
  end

  // R7: a written-1 clear with no coincident event empties the sticky bit
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_CLR) |=> ((sticky & $past(wd & ~evt)) == '0));

  // R8: mask write only removes enables
  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_MASK) |=> (ien == $past(ien & wd)));

  // R8: unmask write only adds enables
  p_unmask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_UNMSK) |=> (ien == $past(ien | wd)));

  // R5: a sticky bit only appears after a detected edge
  p_sticky_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky & ~$past(sticky) & ~$past(evt)) == '0));
endmodule

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v = 1'b0, w = 1'b0, sel2 = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata2;
  logic [31:0] pad = '0;
  logic [7:0] pad2 = '0;
  logic [31:0] pad_out, pad_oe;
  logic [7:0] pad_out2, pad_oe2;
  logic irq, irq2;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_bank dut (.clk(clk), .rst_n(rst_n), .bus_valid(v & ~sel2), .bus_write(w),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .pad_in(pad),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  gpio_irq_bank #(.NPIN(8), .BOTH_EDGE_EN(1'b0)) dut2 (.clk(clk), .rst_n(rst_n),
    .bus_valid(v & sel2), .bus_write(w), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata2), .pad_in(pad2), .pad_out(pad_out2), .pad_oe(pad_oe2), .irq(irq2));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    v = 1; w = 1; addr = a; wdata = d;
    @(negedge clk);
    v = 0; w = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    v = 1; w = 0; addr = a;
    #0.5;
    d = sel2 ? rdata2 : rdata;
    v = 0;
    #0.5;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, k, p, q, m, b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    foreach (r[i]) ;
    for (int a = 0; a <= 8'h4C; a += 4) begin
      rd(a[7:0], r);
      chk("R1 reset register", r, 32'h0);
    end
    chk("R1 reset oe", pad_oe, 0);
    chk("R1 reset irq", {31'h0, irq}, 0);

    // R2 / R3 direction and input-view sweep
    for (int n = 0; n < 3; n++) begin
      k = (n == 0) ? 32'hA5A5_0F0F : (n == 1) ? 32'h1234_5678 : 32'hFFFF_FFFF;
      p = k ^ 32'h3C3C_C3C3;
      q = {k[15:0], k[31:16]} ^ 32'h0F0F_F0F0;
      wr(8'h04, k); wr(8'h08, p); pad = q; settle();
      chk("R2 oe follows dir", pad_oe, k);
      chk("R2 pad_out", pad_out, p);
      rd(8'h0C, r);
      chk("R3 input view", r, (k & p) | (~k & q));
      m = 32'hFF00_00FF;
      wr(8'h00, m);
      chk("R2 oe masked by mode", pad_oe, k & ~m);
      rd(8'h0C, r);
      chk("R3 input view with mode", r, (k & ~m & p) | (~(k & ~m) & q));
      wr(8'h00, 0); wr(8'h04, 0);
    end
    pad = 0; wr(8'h08, 0); settle();

    // R3 two-edge latency
    pad[5] = 1; @(negedge clk);
    rd(8'h0C, r); chk("R3 not yet visible", r, 0);
    @(negedge clk);
    rd(8'h0C, r); chk("R3 visible after two edges", r, 32'h20);
    pad = 0; settle();

    // per-pin sweep of all sense types (R4 R5 R6 R7 R8 R9 R10)
    for (int i = 0; i < 32; i++) begin
      for (int t = 0; t < 5; t++) begin
        logic pl, eg, bt, st;
        b = 32'h1 << i;
        pl = (t == 1) || (t == 3);
        eg = (t >= 2);
        bt = (t == 4);
        pad = 0;
        wr(8'h20, pl ? b : 0);
        wr(8'h24, eg ? b : 0);
        wr(8'h4C, bt ? b : 0);
        wr(8'h00, b);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h1C, b);
        settle();
        if (!eg) begin
          st = pl;
          rd(8'h10, r); chk("R4 level idle", r, st ? b : 0);
          chk("R9 irq level idle", {31'h0, irq}, {31'h0, st});
          pad[i] = 1; settle();
          rd(8'h10, r); chk("R4 level active pad", r, pl ? 0 : b);
          chk("R9 irq level", {31'h0, irq}, {31'h0, ~pl});
          pad[i] = 0; settle();
          rd(8'h10, r); chk("R4 level not latched", r, pl ? b : 0);
        end else begin
          st = 0;
          rd(8'h10, r); chk("R5 edge idle", r, 0);
          pad[i] = 1; settle();
          st = (t == 2) || (t == 4);
          rd(8'h10, r); chk("R5 R6 after rise", r, st ? b : 0);
          chk("R9 irq after rise", {31'h0, irq}, {31'h0, st});
          wr(8'h14, b);
          rd(8'h10, r); chk("R7 clear", r, 0);
          pad[i] = 0; settle();
          st = (t == 3) || (t == 4);
          rd(8'h10, r); chk("R5 R6 after fall", r, st ? b : 0);
          wr(8'h14, ~b);
          rd(8'h10, r); chk("R7 zero bits ignored", r, st ? b : 0);
          wr(8'h18, ~b);
          rd(8'h18, r); chk("R8 mask removes", r, 0);
          chk("R9 irq masked", {31'h0, irq}, 0);
          rd(8'h10, r); chk("R9 status kept when masked", r, st ? b : 0);
          wr(8'h1C, b);
          chk("R9 irq unmasked", {31'h0, irq}, {31'h0, st});
          wr(8'h14, b);
        end
        wr(8'h00, 0);
        rd(8'h10, r); chk("R10 gpio mode no status", r, 0);
        chk("R10 gpio mode no irq", {31'h0, irq}, 0);
        wr(8'h18, 0);
      end
    end
    wr(8'h20, 0); wr(8'h24, 0); wr(8'h4C, 0); pad = 0; settle();

    // R8 set/and semantics on patterns
    wr(8'h1C, 32'h0000_F0F0); wr(8'h1C, 32'h0F00_0F00);
    rd(8'h18, r); chk("R8 unmask ors", r, 32'h0F00_FFF0);
    wr(8'h18, 32'h0FF0_0FF0);
    rd(8'h18, r); chk("R8 mask ands", r, 32'h0F00_0FF0);
    wr(8'h18, 0);

    // R7 clear coincident with event: set wins
    wr(8'h24, 32'h1); wr(8'h00, 32'h1); wr(8'h14, 32'h1);
    pad[0] = 1;
    @(negedge clk); @(negedge clk);
    v = 1; w = 1; addr = 8'h14; wdata = 32'h1;
    @(negedge clk);
    v = 0; w = 0;
    rd(8'h10, r); chk("R7 event beats clear", r, 32'h1);
    wr(8'h14, 32'h1);
    rd(8'h10, r); chk("R7 later clear", r, 0);
    wr(8'h00, 0); wr(8'h24, 0); pad = 0; settle();

    // R11 reads of unused space
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, r); chk("R11 filter reg zero", r, 0);
    rd(8'h40, r); chk("R11 unmapped zero", r, 0);

    // narrow instance without both-edge option
    sel2 = 1;
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h4C, r); chk("R6 both reads zero when absent", r, 0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, r); chk("R11 bits above npin zero", r, 32'hFF);
    wr(8'h04, 0);
    wr(8'h24, 32'h1); wr(8'h00, 32'h1); wr(8'h1C, 32'h1);
    pad2[0] = 1; settle(); wr(8'h14, 32'h1);
    pad2[0] = 0; settle();
    rd(8'h10, r); chk("R6 falling ignored without option", r, 0);
    chk("R6 no irq without option", {31'h0, irq2}, 0);
    pad2[0] = 1; settle();
    rd(8'h10, r); chk("R5 rising on narrow", r, 32'h1);
    chk("R9 irq narrow", {31'h0, irq2}, 32'h1);
    sel2 = 0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule